// File: doc/BRIEF.md
# Scanline-Paced SPI Byte Engine

This block moves one SPI byte at a time, but spreads the transfer over successive display scanlines: each line strobe from the video timing logic triggers exactly one bit step. Because of this pacing, the serial link uses only the idle time left in each line. The bit rate follows the line rate, so the same engine serves a slow or a fast scan mode without any change.

The host first writes the outgoing byte into the data register. It then writes a counter byte. The upper nibble of the counter byte sets how many bit steps remain, and bit 7 doubles as the busy flag. The low bits choose which slave is selected. During each bit step the engine does four things in order:

- presents the data MSB on MOSI;
- raises SCK;
- samples MISO at the end of the high phase and shifts it into the data register;
- lowers SCK, then takes 0x10 off the counter.

When bit 7 of the counter clears, the host reads the received byte from the data register. Sound is muted for the whole time the engine is busy.

Top module: `line_spi_engine`

## Requirements
- R1: After reset the data register, counter register and overrun flag all read 0. SCK is low, every select output is high and the mute output is low.
- R2: A write to the counter register (address 1) while bit 7 of the counter is clear loads the written byte. If that byte has bit 7 set, a transfer starts and the counter reads back with bit 7 set.
- R3: Each line strobe taken during a transfer lowers the counter by exactly 0x10. A start value of 0xF1 ends at 0x71 after eight strobes. Strobes after bit 7 has cleared change nothing.
- R4: Each bit step makes exactly one SCK pulse. SCK goes high HALF_CYC clocks after the step begins, stays high for HALF_CYC clocks and rests low between steps. SCK is never high while the engine is idle.
- R5: MOSI carries the data register MSB during each step, so the outgoing byte is sent MSB first. The sampled MISO bit enters at the LSB (data*2 + bit), so after the last step the data register (address 0) holds the incoming byte, MSB first.
- R6: Counter bits [1:0] pick the select line. Code 1 drives spi_cs_n[0] low, code 2 drives spi_cs_n[1] low, and codes 0 and 3 select nothing. At most one select is low, and the select does not change for the whole transfer.
- R7: After the last step, SCK stays low and the select stays asserted until the next line strobe, which releases it.
- R8: snd_mute is high exactly while counter bit 7 is set.
- R9: While a transfer runs, writes to the counter register and to the data register are ignored. A counter write in that state sets the overrun flag (address 2, bit 0). Any write to address 2 clears the flag.
- R10: A line strobe that arrives while a bit step is still in progress is ignored and adds no step.
- R11: Line strobes while idle, with no select held, leave every output and register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 data, 1 counter, 2 flags |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| line_strobe | input | 1 | One-clock pulse per scanline |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out, MSB of data register |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NSEL | Active-low slave selects |
| snd_mute | output | 1 | Sound mute, high while busy |

## Verification
Full-byte transfers are run at two strobe spacings, a slow one and one just above the step length. This shows that pacing comes from the strobe alone. The transmit and receive bytes are complementary bit patterns (0xA5/0x3C, 0x5A/0xC3), so a reversed shift order, a stuck MOSI or a mis-timed MISO sample each give a distinct wrong byte. A two-step transfer with select code 3 checks that shorter counts stop early and that no select is asserted. Extra strobes injected in the middle of a step, and start writes issued mid-transfer, show that neither one adds a step nor disturbs the counter.

// File: rtl/lspi_pkg.sv
package lspi_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_HIGH  = 2'd2,
    ST_LOW   = 2'd3
  } step_e;

  localparam int unsigned REG_W    = 8;
  localparam logic [7:0]  CNT_STEP = 8'h10;

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_FLAG = 2'd2;

endpackage

// File: rtl/lspi_stepper.sv
// Bit-step sequencer: setup, SCK high, SCK low, each HALF_CYC clocks long.
module lspi_stepper
  import lspi_pkg::*;
#(
  parameter int unsigned HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_strobe,
  input  logic busy,
  output logic sck,
  output logic sample_en,
  output logic step_end,
  output logic step_active
);

  localparam int unsigned TMR_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(HALF_CYC - 1);

  step_e            st_q, st_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             sck_q, sck_d;
  logic             last;

  assign last = (tmr_q == TMR_LAST);

  always_comb begin
    st_d      = st_q;
    tmr_d     = tmr_q;
    sample_en = 1'b0;
    step_end  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (line_strobe && busy) begin
          st_d  = ST_SETUP;
          tmr_d = '0;
        end
      end
      ST_SETUP: begin
        if (last) begin
          st_d  = ST_HIGH;
          tmr_d = '0;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      ST_HIGH: begin
        if (last) begin
          st_d      = ST_LOW;
          tmr_d     = '0;
          sample_en = 1'b1;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      ST_LOW: begin
        if (last) begin
          st_d     = ST_IDLE;
          tmr_d    = '0;
          step_end = 1'b1;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      default: begin
        st_d  = ST_IDLE;
        tmr_d = '0;
      end
    endcase
    sck_d = (st_d == ST_HIGH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      tmr_q <= '0;
      sck_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
      sck_q <= sck_d;
    end
  end

  assign sck         = sck_q;
  assign step_active = (st_q != ST_IDLE);

endmodule

// File: rtl/lspi_regs.sv
// Host-visible data, counter and overrun registers plus select hold.
module lspi_regs
  import lspi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             miso,
  input  logic             sample_en,
  input  logic             step_end,
  input  logic             line_strobe,
  input  logic             step_active,
  output logic [REG_W-1:0] data_q,
  output logic [REG_W-1:0] cnt_q,
  output logic [REG_W-1:0] cnt_d,
  output logic             ovr_q,
  output logic             hold_d
);

  logic             busy;
  logic             wr_data, wr_ctrl, wr_flag;
  logic [REG_W-1:0] data_d;
  logic             data_en, cnt_en, ovr_en, hold_en;
  logic             ovr_d;
  logic             hold_q;

  assign busy    = cnt_q[REG_W-1];
  assign wr_data = reg_we && (reg_addr == A_DATA);
  assign wr_ctrl = reg_we && (reg_addr == A_CTRL);
  assign wr_flag = reg_we && (reg_addr == A_FLAG);

  always_comb begin
    data_en = sample_en || (wr_data && !busy);
    data_d  = sample_en ? {data_q[REG_W-2:0], miso} : reg_wdata;

    cnt_en  = step_end || (wr_ctrl && !busy);
    cnt_d   = cnt_q;
    if (step_end)               cnt_d = cnt_q - CNT_STEP;
    else if (wr_ctrl && !busy)  cnt_d = reg_wdata;

    ovr_en  = (wr_ctrl && busy) || wr_flag;
    ovr_d   = wr_ctrl && busy;

    hold_en = (wr_ctrl && !busy && reg_wdata[REG_W-1]) ||
              (line_strobe && !busy && !step_active);
    hold_d  = hold_q;
    if (wr_ctrl && !busy && reg_wdata[REG_W-1])          hold_d = 1'b1;
    else if (line_strobe && !busy && !step_active)       hold_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      cnt_q  <= '0;
      ovr_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      if (data_en) data_q <= data_d;
      if (cnt_en)  cnt_q  <= cnt_d;
      if (ovr_en)  ovr_q  <= ovr_d;
      if (hold_en) hold_q <= hold_d;
    end
  end

endmodule

// File: rtl/lspi_select.sv
// Registered one-of-N select decode from next-state hold and counter code.
module lspi_select #(
  parameter int unsigned NSEL = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold_d,
  input  logic [SEL_W-1:0] code_d,
  output logic [NSEL-1:0] cs_n
);

  localparam int unsigned SEL_W = $clog2(NSEL + 1);

  logic [NSEL-1:0] cs_n_d;

  for (genvar i = 0; i < NSEL; i++) begin : g_sel
    assign cs_n_d[i] = !(hold_d && (code_d == SEL_W'(i + 1)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_n <= '1;
    else        cs_n <= cs_n_d;
  end

endmodule

// File: rtl/line_spi_engine.sv
module line_spi_engine
  import lspi_pkg::*;
#(
  parameter int unsigned HALF_CYC = 4,
  parameter int unsigned NSEL     = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [1:0]      reg_addr,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  input  logic            line_strobe,
  output logic            spi_sck,
  output logic            spi_mosi,
  input  logic            spi_miso,
  output logic [NSEL-1:0] spi_cs_n,
  output logic            snd_mute
);

  localparam int unsigned SEL_W = $clog2(NSEL + 1);

  logic [1:0]       rst_sync_q;
  logic             rst_ni;
  logic [REG_W-1:0] data_q, cnt_q, cnt_d;
  logic             ovr_q, hold_d;
  logic             sample_en, step_end, step_active;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  lspi_stepper #(.HALF_CYC(HALF_CYC)) u_step (
    .clk        (clk),
    .rst_n      (rst_ni),
    .line_strobe(line_strobe),
    .busy       (cnt_q[REG_W-1]),
    .sck        (spi_sck),
    .sample_en  (sample_en),
    .step_end   (step_end),
    .step_active(step_active)
  );

  lspi_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_ni),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .miso       (spi_miso),
    .sample_en  (sample_en),
    .step_end   (step_end),
    .line_strobe(line_strobe),
    .step_active(step_active),
    .data_q     (data_q),
    .cnt_q      (cnt_q),
    .cnt_d      (cnt_d),
    .ovr_q      (ovr_q),
    .hold_d     (hold_d)
  );

  lspi_select #(.NSEL(NSEL)) u_sel (
    .clk   (clk),
    .rst_n (rst_ni),
    .hold_d(hold_d),
    .code_d(cnt_d[SEL_W-1:0]),
    .cs_n  (spi_cs_n)
  );

  always_comb begin
    unique case (reg_addr)
      A_DATA:  reg_rdata = data_q;
      A_CTRL:  reg_rdata = cnt_q;
      A_FLAG:  reg_rdata = {7'b0, ovr_q};
      default: reg_rdata = 8'h00;
    endcase
  end

  assign spi_mosi = data_q[REG_W-1];
  assign snd_mute = cnt_q[REG_W-1];

endmodule

// File: rtl/lspi_checker.sv
module lspi_checker #(
  parameter int unsigned NSEL = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_we,
  input logic [1:0]      reg_addr,
  input logic [7:0]      reg_wdata,
  input logic            line_strobe,
  input logic            spi_sck,
  input logic [NSEL-1:0] spi_cs_n,
  input logic            snd_mute,
  input logic [7:0]      cnt_q,
  input logic            ovr_q
);

  // R6: never more than one slave selected
  p_one_select_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~spi_cs_n));

  // R6: select frozen while the transfer runs
  p_select_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_mute && $past(snd_mute)) |-> $stable(spi_cs_n));

  // R4: SCK only pulses inside a transfer
  p_sck_in_xfer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> snd_mute);

  // R3: counter moves only by one step of 0x10 unless the host loads it
  p_step_size_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_we && reg_addr == 2'd1) |->
      (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - 8'h10));

  // R9: counter write during a transfer raises overrun
  p_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd1 && snd_mute) |=> ovr_q);

  // R7: strobe while idle releases the select
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(line_strobe && !snd_mute && !(reg_we && reg_addr == 2'd1 && reg_wdata[7]))
      |-> (&spi_cs_n));

endmodule

bind line_spi_engine lspi_checker #(.NSEL(NSEL)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .line_strobe(line_strobe),
  .spi_sck    (spi_sck),
  .spi_cs_n   (spi_cs_n),
  .snd_mute   (snd_mute),
  .cnt_q      (cnt_q),
  .ovr_q      (ovr_q)
);

// File: tb/sim_line_spi_engine.sv
module sim_line_spi_engine;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int NSEL       = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_we;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       line_strobe;
  logic       spi_sck, spi_mosi, spi_miso, snd_mute;
  logic [NSEL-1:0] spi_cs_n;

  int n_chk = 0;
  int n_bad = 0;
  int sck_rises = 0;
  int slv_idx = 0;
  int slv_base = 0;
  logic [7:0] slv_byte = 8'h00;
  logic [2:0] exp_q[$];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_spi_engine #(.HALF_CYC(HALF), .NSEL(NSEL)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .line_strobe(line_strobe),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n), .snd_mute(snd_mute)
  );

  // slave model: MSB first, next bit after each falling SCK
  always @(negedge spi_sck) slv_idx <= slv_idx + 1;
  assign spi_miso = (&spi_cs_n) ? 1'b0 : slv_byte[3'(7 - (slv_idx - slv_base))];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pop expected {cs_n, mosi} per rising SCK
  always @(posedge spi_sck) begin
    logic [2:0] e;
    sck_rises++;
    if (exp_q.size() == 0) begin
      check(1'b0, "R4 unexpected SCK pulse", 1, 0);
    end else begin
      e = exp_q.pop_front();
      check(spi_mosi == e[0], "R5 MOSI bit", int'(spi_mosi), int'(e[0]));
      check(spi_cs_n == e[2:1], "R6 select during bit", int'(spi_cs_n), int'(e[2:1]));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse();
    @(negedge clk);
    line_strobe = 1'b1;
    @(negedge clk);
    line_strobe = 1'b0;
  endtask

  function automatic logic [1:0] sel_of(input logic [7:0] code);
    if (code[1:0] == 2'd1) return 2'b10;
    if (code[1:0] == 2'd2) return 2'b01;
    return 2'b11;
  endfunction

  // driver: queues expected bits, runs the steps, checks the result
  task automatic xfer(input logic [7:0] tx, input logic [7:0] rx, input logic [7:0] code,
                      input int gap, input bit inject, input bit overrun);
    logic [7:0] v, exp_rx;
    logic [1:0] cs;
    int steps, base;
    cs = sel_of(code);
    steps = int'(code[7:4]) - 7;
    wr(2'd0, tx);
    slv_byte = rx;
    slv_base = slv_idx;
    exp_rx = tx;
    for (int i = 0; i < steps; i++) begin
      exp_q.push_back({cs, tx[7-i]});
      exp_rx = {exp_rx[6:0], (cs == 2'b11) ? 1'b0 : rx[7-i]};
    end
    wr(2'd1, code);
    rd(2'd1, v);
    check(v == code, "R2 counter after start", v, code);
    check(snd_mute == 1'b1, "R8 mute while busy", snd_mute, 1);
    check(spi_cs_n == cs, "R6 select at start", spi_cs_n, cs);
    base = sck_rises;
    for (int k = 0; k < steps; k++) begin
      pulse();
      if (inject && k == 0) begin
        repeat (3) @(negedge clk);
        pulse();
      end
      repeat (gap) @(negedge clk);
      rd(2'd1, v);
      check(v == code - 8'(16*(k+1)), "R3 counter per strobe", v, code - 8'(16*(k+1)));
      check(sck_rises == base + k + 1, inject ? "R10 one step per strobe" : "R4 one pulse per step",
            sck_rises, base + k + 1);
      if (overrun && k == 2) begin
        wr(2'd1, 8'hF2);
        wr(2'd0, 8'h00);
        rd(2'd1, v);
        check(v == code - 8'h30, "R9 start ignored while busy", v, code - 8'h30);
        rd(2'd2, v);
        check(v == 8'h01, "R9 overrun flag set", v, 1);
        wr(2'd2, 8'h00);
        rd(2'd2, v);
        check(v == 8'h00, "R9 overrun flag cleared", v, 0);
      end
    end
    check(snd_mute == 1'b0, "R8 mute off when done", snd_mute, 0);
    rd(2'd0, v);
    check(v == exp_rx, "R5 received byte", v, exp_rx);
    check(spi_cs_n == cs, "R7 select held until strobe", spi_cs_n, cs);
    check(spi_sck == 1'b0, "R7 SCK rests low", spi_sck, 0);
    pulse();
    @(negedge clk);
    check(spi_cs_n == 2'b11, "R7 select released", spi_cs_n, 3);
    base = sck_rises;
    pulse();
    repeat (gap) @(negedge clk);
    rd(2'd1, v);
    check(v == code - 8'(16*steps), "R3 no step after end", v, code - 8'(16*steps));
    check(sck_rises == base, "R3 no pulse after end", sck_rises, base);
  endtask

  initial begin : main
    logic [7:0] v;
    int base;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00; line_strobe = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(2'd0, v); check(v == 8'h00, "R1 data reset", v, 0);
    rd(2'd1, v); check(v == 8'h00, "R1 counter reset", v, 0);
    rd(2'd2, v); check(v == 8'h00, "R1 overrun reset", v, 0);
    check(spi_sck == 1'b0 && spi_cs_n == 2'b11 && snd_mute == 1'b0, "R1 outputs reset",
          {spi_sck, spi_cs_n, snd_mute}, 6);

    // R11: idle strobes
    base = sck_rises;
    for (int i = 0; i < 3; i++) begin
      pulse();
      repeat (14) @(negedge clk);
    end
    rd(2'd1, v);
    check(v == 8'h00 && sck_rises == base && spi_cs_n == 2'b11, "R11 idle strobes inert",
          {v, 4'(sck_rises - base)}, 0);

    xfer(8'hA5, 8'h3C, 8'hF1, 20, 1'b0, 1'b1);
    xfer(8'h5A, 8'hC3, 8'hF2, 14, 1'b1, 1'b0);
    xfer(8'hC0, 8'hFF, 8'h93, 16, 1'b0, 1'b0);

    check(exp_q.size() == 0, "R4 all expected pulses seen", exp_q.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule